// File: doc/BRIEF.md
# Port-Aware Low-Power Mode Controller

This block decides how far a physical-layer device may power down while its link-layer interface is idle. It watches the state of the link interface, the status of the single cable port, the port interrupt enable, the low-power request level (`lps`, assumed already filtered into a clean level) and three port event strobes. From these it chooses one of three power levels: active, low-power, or ultralow-power sleep. It drives an enable for the internal clock generators, a three-bit enable vector for the reference circuits, a one-cycle wake strobe, and a request to start up the link interface.

The device sleeps only when the link interface is disabled and the port carries no live connection. The depth of sleep follows the port. A disconnected port needs only connection detection. So does a disabled port whose interrupt is masked. A suspended port, or a disabled port with its interrupt enabled, must keep the bias and disconnect detectors running. Raising `lps` wakes the device. So does any port event that must be serviced or reported. The repeater datapath is outside this block and is treated as always running.

Top module: `lpm_ctrl`

## Requirements
- R1: While synchronous reset `rst` is high, and on the first cycle after it, `pwr_level` is 2'b00 (active), `clk_gen_en` is 1, `ref_en` is 3'b111 and `wake_pulse` is 0.
- R2: The block leaves the active level only after the sleep condition has held on ENTRY_HOLD consecutive clock edges (default 4). The sleep condition is: `link_state` == 2'b10 (disabled; 2'b00 is normal, 2'b01 is reset), `port_state` not 2'b00 (connected), `lps` low, and no qualified port event.
- R3: The sleep target is 2'b10 (ultralow-power) when `port_state` is 2'b01 (disconnected), or when it is 2'b10 (disabled) with `port_irq_en` = 0. The target is 2'b01 (low-power) when `port_state` is 2'b11 (suspended), or 2'b10 with `port_irq_en` = 1. While asleep, the level follows the target on every edge.
- R4: `ref_en` bit 0 (connection detection) is on at every level. Bit 1 (bias and disconnect detection) is on at active and low-power. Bit 2 (bulk references) is on only at active. This gives 3'b111, 3'b011 and 3'b001.
- R5: While asleep, `lps` high at a clock edge returns the level to active on that edge.
- R6: While asleep, these events wake the block on the edge that samples them: `evt_bias` on a suspended port, `evt_disconnect` on a suspended port, and `evt_connect` on any port not disabled. All other events leave the level unchanged, for example `evt_bias` on a disabled port.
- R7: `wake_pulse` is high for exactly one cycle, and that cycle is the first cycle at the active level after a sleep level.
- R8: `clk_gen_en` equals "level was active" delayed by CLK_EN_DELAY cycles (default 1). After a wake, the clock enable therefore returns only after the level is already active.
- R9: `pwr_level` never holds 2'b11.
- R10: While asleep, `link_state` leaving 2'b10, or `port_state` becoming 2'b00, returns the level to active with a wake pulse.
- R11: `intf_start_req` is high exactly when `clk_gen_en` is 1, `lps` is 1 and `link_state` is not 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| link_state | input | 2 | Link interface state: 00 normal, 01 reset, 10 disabled |
| port_state | input | 2 | Port status: 00 connected, 01 disconnected, 10 disabled, 11 suspended |
| port_irq_en | input | 1 | Port interrupt enable bit |
| lps | input | 1 | Filtered low-power request level (high = interface wanted) |
| evt_bias | input | 1 | Strobe: incoming bias detected |
| evt_disconnect | input | 1 | Strobe: disconnection detected |
| evt_connect | input | 1 | Strobe: new connection detected |
| pwr_level | output | 2 | Power level: 00 active, 01 low-power, 10 ultralow-power |
| clk_gen_en | output | 1 | Enable for internal clock generators |
| ref_en | output | 3 | Reference circuit enables (bit0 connect, bit1 bias/disconnect, bit2 bulk) |
| wake_pulse | output | 1 | One-cycle strobe on return to active |
| intf_start_req | output | 1 | Request to start up the link interface |

## Verification
The assertions take the link code 2'b11 as unused, treat `lps` as an already qualified level, and assume that CLK_EN_DELAY does not exceed ENTRY_HOLD. The clock-rise check is only built under that last condition. The stimulus draws `link_state` only from the three defined codes. It biases that draw toward the disabled code and `lps` toward low, so that sleep entry and every wake path occur often. The event strobes are drawn independently of port status, so the bench meets both qualified and ignored events.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

   typedef enum logic [1:0] {
      LVL_ACTIVE = 2'b00,
      LVL_LOW    = 2'b01,
      LVL_ULP    = 2'b10
   } lvl_e;

   localparam logic [1:0] LINK_NORMAL   = 2'b00;
   localparam logic [1:0] LINK_RESET    = 2'b01;
   localparam logic [1:0] LINK_DISABLED = 2'b10;

   localparam logic [1:0] PORT_CONN   = 2'b00;
   localparam logic [1:0] PORT_DISC   = 2'b01;
   localparam logic [1:0] PORT_OFF    = 2'b10;
   localparam logic [1:0] PORT_SUSP   = 2'b11;

   localparam int REF_W    = 3;
   localparam int REF_CONN = 0;
   localparam int REF_BIAS = 1;
   localparam int REF_BULK = 2;

   function automatic logic [REF_W-1:0] ref_mask(input lvl_e lvl);
      logic [REF_W-1:0] m;
      m = '0;
      m[REF_CONN] = 1'b1;
      m[REF_BIAS] = (lvl != LVL_ULP);
      m[REF_BULK] = (lvl == LVL_ACTIVE);
      return m;
   endfunction

endpackage

// File: rtl/lpm_wake_qual.sv
module lpm_wake_qual
   import lpm_pkg::*;
#(
   parameter bit DEEP_SLEEP_EN = 1'b1
) (
   input  logic [1:0] link_state,
   input  logic [1:0] port_state,
   input  logic       port_irq_en,
   input  logic       lps,
   input  logic       evt_bias,
   input  logic       evt_disconnect,
   input  logic       evt_connect,
   output logic       sleep_ok,
   output lvl_e       tgt_lvl
);

   logic port_idle;
   logic qual_evt;

   always_comb begin
      port_idle = (port_state != PORT_CONN);
      qual_evt  = (evt_bias       && (port_state == PORT_SUSP))
                | (evt_disconnect && (port_state == PORT_SUSP))
                | (evt_connect    && (port_state != PORT_OFF));
      sleep_ok  = (link_state == LINK_DISABLED) && port_idle && !lps && !qual_evt;
   end

   generate
      if (DEEP_SLEEP_EN) begin : g_deep
         logic deep_sel;
         always_comb begin
            deep_sel = (port_state == PORT_DISC)
                     || ((port_state == PORT_OFF) && !port_irq_en);
            tgt_lvl  = deep_sel ? LVL_ULP : LVL_LOW;
         end
      end else begin : g_shallow
         logic unused_irq;
         always_comb begin
            unused_irq = port_irq_en;
            tgt_lvl    = LVL_LOW;
         end
      end
   endgenerate

endmodule

// File: rtl/lpm_entry_timer.sv
module lpm_entry_timer #(
   parameter int ENTRY_HOLD = 4
) (
   input  logic clk,
   input  logic rst,
   input  logic run,
   output logic fire
);

   localparam int CNT_W = $clog2(ENTRY_HOLD + 1);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(ENTRY_HOLD - 1);

   logic [CNT_W-1:0] cnt_q;

   generate
      if (ENTRY_HOLD < 1) begin : g_bad_hold
         $error("ENTRY_HOLD must be at least 1");
      end
   endgenerate

   assign fire = run && (cnt_q == LAST);

   always_ff @(posedge clk) begin
      if (rst || !run || fire) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   // R2: the hold counter never runs past the programmed window
   p_cnt_bound_r2: assert property (@(posedge clk) disable iff (rst)
      cnt_q <= LAST);

   // R2: counting restarts whenever the condition drops
   p_cnt_clear_r2: assert property (@(posedge clk) disable iff (rst)
      !run |=> (cnt_q == '0));

endmodule

// File: rtl/lpm_clk_en_dly.sv
module lpm_clk_en_dly #(
   parameter int CLK_EN_DELAY = 1
) (
   input  logic clk,
   input  logic rst,
   input  logic active_now,
   output logic clk_en
);

   generate
      if (CLK_EN_DELAY < 1) begin : g_bad_dly
         $error("CLK_EN_DELAY must be at least 1");
      end

      if (CLK_EN_DELAY == 1) begin : g_single
         logic en_q;
         always_ff @(posedge clk) begin
            if (rst) en_q <= 1'b1;
            else     en_q <= active_now;
         end
         assign clk_en = en_q;
      end else begin : g_chain
         logic [CLK_EN_DELAY-1:0] sr_q;
         always_ff @(posedge clk) begin
            if (rst) sr_q <= '1;
            else     sr_q <= {sr_q[CLK_EN_DELAY-2:0], active_now};
         end
         assign clk_en = sr_q[CLK_EN_DELAY-1];
      end
   endgenerate

   // R8: the enable only changes after the level input has changed
   p_clk_follows_r8: assert property (@(posedge clk) disable iff (rst)
      $rose(clk_en) |-> $past(active_now));

endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
   import lpm_pkg::*;
#(
   parameter int ENTRY_HOLD    = 4,
   parameter int CLK_EN_DELAY  = 1,
   parameter bit DEEP_SLEEP_EN = 1'b1
) (
   input  logic       clk,
   input  logic       rst,
   input  logic [1:0] link_state,
   input  logic [1:0] port_state,
   input  logic       port_irq_en,
   input  logic       lps,
   input  logic       evt_bias,
   input  logic       evt_disconnect,
   input  logic       evt_connect,
   output logic [1:0] pwr_level,
   output logic       clk_gen_en,
   output logic [2:0] ref_en,
   output logic       wake_pulse,
   output logic       intf_start_req
);

   localparam bit CLK_CHECK_OK = (CLK_EN_DELAY <= ENTRY_HOLD);

   lvl_e lvl_q;
   lvl_e tgt_lvl;
   logic sleep_ok;
   logic entry_fire;
   logic wake_q;
   logic is_active;

   assign is_active = (lvl_q == LVL_ACTIVE);

   lpm_wake_qual #(
      .DEEP_SLEEP_EN (DEEP_SLEEP_EN)
   ) u_qual (
      .link_state     (link_state),
      .port_state     (port_state),
      .port_irq_en    (port_irq_en),
      .lps            (lps),
      .evt_bias       (evt_bias),
      .evt_disconnect (evt_disconnect),
      .evt_connect    (evt_connect),
      .sleep_ok       (sleep_ok),
      .tgt_lvl        (tgt_lvl)
   );

   lpm_entry_timer #(
      .ENTRY_HOLD (ENTRY_HOLD)
   ) u_timer (
      .clk  (clk),
      .rst  (rst),
      .run  (is_active && sleep_ok),
      .fire (entry_fire)
   );

   lpm_clk_en_dly #(
      .CLK_EN_DELAY (CLK_EN_DELAY)
   ) u_clk_dly (
      .clk        (clk),
      .rst        (rst),
      .active_now (is_active),
      .clk_en     (clk_gen_en)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         lvl_q  <= LVL_ACTIVE;
         wake_q <= 1'b0;
      end else if (is_active) begin
         wake_q <= 1'b0;
         if (entry_fire) lvl_q <= tgt_lvl;
      end else if (!sleep_ok) begin
         lvl_q  <= LVL_ACTIVE;
         wake_q <= 1'b1;
      end else begin
         lvl_q  <= tgt_lvl;
         wake_q <= 1'b0;
      end
   end

   assign pwr_level      = lvl_q;
   assign ref_en         = ref_mask(lvl_q);
   assign wake_pulse     = wake_q;
   assign intf_start_req = clk_gen_en && lps && (link_state != LINK_NORMAL);

   // R9: only three encodings are ever held
   p_lvl_legal_r9: assert property (@(posedge clk) disable iff (rst)
      pwr_level != 2'b11);

   // R7: the strobe marks the first active cycle after sleep
   p_wake_marks_r7: assert property (@(posedge clk) disable iff (rst)
      wake_pulse |-> (pwr_level == 2'b00) && ($past(pwr_level) != 2'b00));

   // R7: never two strobes back to back
   p_wake_single_r7: assert property (@(posedge clk) disable iff (rst)
      wake_pulse |=> !wake_pulse);

   // R2: leaving active requires a disabled link, idle port and low lps
   p_entry_cond_r2: assert property (@(posedge clk) disable iff (rst)
      ((pwr_level != 2'b00) && ($past(pwr_level) == 2'b00)) |->
         (($past(link_state) == LINK_DISABLED) && ($past(port_state) != PORT_CONN)
          && !$past(lps)));

   // R5: lps seen high while asleep brings the level back
   p_lps_wake_r5: assert property (@(posedge clk) disable iff (rst)
      (($past(pwr_level) != 2'b00) && $past(lps)) |-> (pwr_level == 2'b00));

   // R4: bulk references are off whenever the level is not active
   p_bulk_off_r4: assert property (@(posedge clk) disable iff (rst)
      (pwr_level != 2'b00) |-> !ref_en[REF_BULK]);

   generate
      if (DEEP_SLEEP_EN) begin : g_deep_chk
         // R3: deepest level only for a disconnected or masked disabled port
         p_deep_cond_r3: assert property (@(posedge clk) disable iff (rst)
            (pwr_level == 2'b10) |->
               (($past(port_state) == PORT_DISC)
                || (($past(port_state) == PORT_OFF) && !$past(port_irq_en))));
      end
      if (CLK_CHECK_OK) begin : g_clk_chk
         // R8: clocks come back only once the level is active
         p_clk_after_active_r8: assert property (@(posedge clk) disable iff (rst)
            $rose(clk_gen_en) |-> (pwr_level == 2'b00));
      end
   endgenerate

endmodule

// File: tb/lpm_ctrl_bench.sv
module lpm_ctrl_bench;

   localparam int HOLD = 4;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [1:0] link = 2'b10;
   logic [1:0] port = 2'b01;
   logic       irq = 1'b0;
   logic       lps_i = 1'b0;
   logic       eb = 1'b0;
   logic       ed = 1'b0;
   logic       ec = 1'b0;

   logic [1:0] pwr_level;
   logic       clk_gen_en;
   logic [2:0] ref_en;
   logic       wake_pulse;
   logic       intf_start_req;

   int tests = 0;
   int fails = 0;
   int cycles = 0;
   bit done = 1'b0;

   int m_lvl = 0;
   int m_cnt = 0;
   int m_clk = 1;
   int m_wake = 0;

   always #2.5 clk = ~clk;

   lpm_ctrl u_lpm_ctrl (
      .clk            (clk),
      .rst            (rst),
      .link_state     (link),
      .port_state     (port),
      .port_irq_en    (irq),
      .lps            (lps_i),
      .evt_bias       (eb),
      .evt_disconnect (ed),
      .evt_connect    (ec),
      .pwr_level      (pwr_level),
      .clk_gen_en     (clk_gen_en),
      .ref_en         (ref_en),
      .wake_pulse     (wake_pulse),
      .intf_start_req (intf_start_req)
   );

   task automatic chk(input string req, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cycles);
      end
   endtask

   function automatic int exp_ref(input int lvl);
      if (lvl == 0) return 7;
      if (lvl == 1) return 3;
      return 1;
   endfunction

   function automatic bit qualified(input int p, input bit b, input bit d, input bit c);
      return (b && p == 3) || (d && p == 3) || (c && p != 2);
   endfunction

   function automatic int target(input int p, input bit ie);
      return (p == 1 || (p == 2 && !ie)) ? 2 : 1;
   endfunction

   // advance the requirement model by one clock edge using the applied inputs
   task automatic model_step();
      bit ok;
      ok = (link == 2) && (port != 0) && !lps_i && !qualified(port, eb, ed, ec);
      m_clk = (m_lvl == 0) ? 1 : 0;
      if (m_lvl == 0) begin
         m_wake = 0;
         if (!ok) m_cnt = 0;
         else if (m_cnt == HOLD - 1) begin
            m_cnt = 0;
            m_lvl = target(port, irq);
         end else m_cnt++;
      end else if (!ok) begin
         m_lvl = 0;
         m_wake = 1;
         m_cnt = 0;
      end else begin
         m_lvl = target(port, irq);
         m_wake = 0;
      end
   endtask

   task automatic compare_all();
      chk("R3/R9 level", pwr_level, m_lvl);
      chk("R8 clk_gen_en", clk_gen_en, m_clk);
      chk("R4 ref_en", ref_en, exp_ref(m_lvl));
      chk("R7 wake_pulse", wake_pulse, m_wake);
      chk("R11 intf_start_req", intf_start_req,
          (m_clk == 1 && lps_i && link != 0) ? 1 : 0);
   endtask

   task automatic step(input logic [1:0] l, input logic [1:0] p, input bit ie,
                       input bit lp, input bit b, input bit d, input bit c);
      link = l; port = p; irq = ie; lps_i = lp; eb = b; ed = d; ec = c;
      @(negedge clk);
      model_step();
      compare_all();
   endtask

   initial begin : watchdog
      while (cycles < 150000 && !done) begin
         @(posedge clk);
         cycles++;
      end
      if (!done) begin
         fails++;
         tests++;
         $display("FAIL watchdog: actual %0d expected below %0d cycles", cycles, 150000);
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin : main
      void'($urandom(32'h5eed_1a7e));
      repeat (3) @(negedge clk);
      // R1: reset values
      chk("R1 level", pwr_level, 0);
      chk("R1 clk_gen_en", clk_gen_en, 1);
      chk("R1 ref_en", ref_en, 7);
      chk("R1 wake_pulse", wake_pulse, 0);
      rst = 1'b0;
      link = 2'b00;
      @(negedge clk);
      chk("R1 level after release", pwr_level, 0);

      // R2: normal link never sleeps
      for (int i = 0; i < 10; i++) step(2'b00, 2'b01, 0, 0, 0, 0, 0);
      chk("R2 stays active on normal link", pwr_level, 0);

      // R2 + R3: disconnected port enters deepest level after the hold window
      for (int i = 0; i < HOLD - 1; i++) step(2'b10, 2'b01, 0, 0, 0, 0, 0);
      chk("R2 still active before window ends", pwr_level, 0);
      step(2'b10, 2'b01, 0, 0, 0, 0, 0);
      chk("R3 ultralow entered", pwr_level, 2);
      chk("R4 ultralow refs", ref_en, 1);
      chk("R8 clock lags entry", clk_gen_en, 1);
      step(2'b10, 2'b01, 0, 0, 0, 0, 0);
      chk("R8 clock off", clk_gen_en, 0);

      // R3: disabled port with interrupt enable moves to low-power
      step(2'b10, 2'b10, 1, 0, 0, 0, 0);
      chk("R3 moves to low-power", pwr_level, 1);
      chk("R4 low-power refs", ref_en, 3);

      // R6: bias on a disabled port is ignored
      step(2'b10, 2'b10, 1, 0, 1, 0, 0);
      chk("R6 bias on disabled port ignored", pwr_level, 1);
      chk("R6 no wake strobe", wake_pulse, 0);

      // R6 + R7: bias on a suspended port wakes
      step(2'b10, 2'b11, 0, 0, 1, 0, 0);
      chk("R6 bias on suspended wakes", pwr_level, 0);
      chk("R7 strobe raised", wake_pulse, 1);
      chk("R8 clock still off at wake", clk_gen_en, 0);
      step(2'b10, 2'b11, 0, 0, 0, 0, 0);
      chk("R7 strobe single cycle", wake_pulse, 0);
      chk("R8 clock back after active", clk_gen_en, 1);

      // R5 + R11: lps wake from low-power
      for (int i = 0; i < HOLD + 2; i++) step(2'b10, 2'b11, 0, 0, 0, 0, 0);
      chk("R3 suspended gives low-power", pwr_level, 1);
      step(2'b10, 2'b11, 0, 1, 0, 0, 0);
      chk("R5 lps wakes", pwr_level, 0);
      chk("R11 no start while clock off", intf_start_req, 0);
      step(2'b10, 2'b11, 0, 1, 0, 0, 0);
      chk("R11 start requested", intf_start_req, 1);
      step(2'b00, 2'b11, 0, 1, 0, 0, 0);
      chk("R11 no start on normal link", intf_start_req, 0);

      // R10: link leaving disabled wakes
      for (int i = 0; i < HOLD + 1; i++) step(2'b10, 2'b01, 0, 0, 0, 0, 0);
      chk("R10 asleep before link change", pwr_level, 2);
      step(2'b01, 2'b01, 0, 0, 0, 0, 0);
      chk("R10 link change wakes", pwr_level, 0);
      chk("R10 wake strobe", wake_pulse, 1);

      // R10: port becoming connected wakes; R6 connect on disconnected wakes
      for (int i = 0; i < HOLD + 1; i++) step(2'b10, 2'b01, 0, 0, 0, 0, 0);
      step(2'b10, 2'b01, 0, 0, 0, 0, 1);
      chk("R6 connect event wakes", pwr_level, 0);
      for (int i = 0; i < HOLD + 1; i++) step(2'b10, 2'b01, 0, 0, 0, 0, 0);
      step(2'b10, 2'b00, 0, 0, 0, 0, 0);
      chk("R10 connected port wakes", pwr_level, 0);

      // random phase checked against the model
      for (int i = 0; i < 4000; i++) begin
         logic [1:0] l;
         l = ($urandom % 8 < 6) ? 2'b10 : 2'($urandom % 2);
         step(l, 2'($urandom % 4), 1'($urandom % 2), ($urandom % 16) == 0,
              ($urandom % 24) == 0, ($urandom % 24) == 0, ($urandom % 24) == 0);
      end

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule